// File: doc/BRIEF.md
# Critical Interrupt Status Encoder

This block gathers four critical interrupt sources and presents the pending one to software as a 3-bit encoded status field in one 32-bit register. The field has a pending flag and a 2-bit source code. The four sources are an external interrupt pin, a timer tick, a summary line from high-priority peripherals, and a deep-sleep wakeup request. The pin can be sampled as a level or latched on its rising edge. The wakeup request is always latched. While it is pending, the block holds a power-down output asserted.

Software reads the register through a single-cycle bus port. Once the flag is set, the field keeps the reported source until software writes 1 to the flag bit. That write makes the encoder evaluate the sources again. The same write clears a latched pin edge, and it acknowledges the wakeup when the wakeup code is the one being reported. The same register shows a read-only copy of the routing setting. That setting steers the combined critical request either to the critical output or to the normal interrupt output.

Top module: `crit_stat_enc`

## Requirements
- R1: A read of the status address (0) returns the pending flag at bit 10, the source code at bits 9:8 and the routing copy (`route_norm_i`) at bit 0. All other bits read 0, any other address reads 0, and after reset the register reads 0.
- R2: Source codes are 00 for the pin, 01 for the timer, 10 for the peripheral summary and 11 for the wakeup. When several sources are active, the smallest code is reported.
- R3: With `pin_edge_i`=1, a rising edge on `pin_irq_i` is latched and stays pending after the pin falls. With `pin_edge_i`=0 the pin is reported only while it is high, and nothing stays latched.
- R4: While the flag is 0, the field takes the encoder result at every clock edge. Once the flag is 1, the flag and the code stay frozen until a flag write.
- R5: A write to the status address with bit 10 set clears the field at the next edge, and the field captures a new evaluation one edge later. A write with bit 10 clear has no effect.
- R6: A latched pin edge is cleared by a flag write or by a pulse on `pin_clr_i`. Both may be used in the same cycle. If a new rising edge arrives in the same cycle as a clear, the edge wins.
- R7: A rising edge on `wake_req_i` sets the wakeup pending and asserts `pwr_hold_o`. Both stay set until a flag write while the field reports flag 1 with code 11. A flag write while any other code is reported leaves them set.
- R8: The OR of the enabled active sources drives `crit_irq_o` when `route_norm_i`=0 and drives `norm_irq_o` when it is 1. The other output stays 0.
- R9: A source whose `src_en_i` bit is 0 (bit index equals its code) is neither reported nor drives an output. `pwr_hold_o` does not depend on the enables.
- R10: A read has no side effect on the field, the latches or the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_irq_i | input | 1 | External interrupt pin, already synchronised |
| pin_edge_i | input | 1 | 1 selects edge latching for the pin, 0 selects level |
| pin_clr_i | input | 1 | Pulse that clears the latched pin edge |
| tmr_tick_i | input | 1 | Timer 0 request, level |
| phi_sum_i | input | 1 | High-priority peripheral summary, level |
| wake_req_i | input | 1 | Deep-sleep wakeup request, latched on its rising edge |
| src_en_i | input | 4 | Per-source enable, index equals the source code |
| route_norm_i | input | 1 | 1 steers critical requests to the normal output |
| reg_addr_i | input | 4 | Register address |
| reg_we_i | input | 1 | Write enable |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational |
| crit_irq_o | output | 1 | Critical interrupt request |
| norm_irq_o | output | 1 | Critical request steered to the normal interrupt line |
| pwr_hold_o | output | 1 | Power-down hold, high while a wakeup waits for acknowledge |

## Verification
Random cycles mix pin toggles, switches between edge and level mode, timer and peripheral levels, sparse wakeup pulses, enable masks, routing flips and writes with or without the flag bit. Every cycle is compared against a bench model of the field, the latches and the outputs. Directed runs with several sources active at once show whether the priority order is right. A pin pulse that drops before it is read shows whether edge latching differs from level sampling. Flag writes issued while a non-wakeup code is frozen show whether an acknowledge is wrongly accepted from the wrong code. A write with the flag bit clear and plain reads show that neither one disturbs the state.

// File: rtl/cse_pkg.sv
// Shared types for the critical interrupt status encoder.
// Assumes four sources whose codes equal their request-vector index.
package cse_pkg;
    localparam int N_SRC  = 4;
    localparam int CODE_W = $clog2(N_SRC);

    typedef enum logic [CODE_W-1:0] {
        SRC_PIN  = 2'd0,
        SRC_TMR  = 2'd1,
        SRC_PHI  = 2'd2,
        SRC_WAKE = 2'd3
    } src_code_e;
endpackage

// File: rtl/cse_pin_src.sv
// External pin source: level pass-through or rising-edge latch.
// Assumes pin_i is already synchronous to clk. In level mode the latch is held clear.
module cse_pin_src (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic edge_mode_i,
    input  logic clr_i,
    input  logic en_i,
    output logic req_o
);
    logic pin_prev_q;
    logic lat_q;
    logic rise;

    assign rise = edge_mode_i & pin_i & ~pin_prev_q;

    // Keep last pin value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_prev_q <= 1'b0;
        else        pin_prev_q <= pin_i;
    end

    // Edge latch: a new edge wins over a clear; level mode keeps it empty.
    always_ff @(posedge clk) begin
        if (!rst_n)            lat_q <= 1'b0;
        else if (!edge_mode_i) lat_q <= 1'b0;
        else if (rise)         lat_q <= 1'b1;
        else if (clr_i)        lat_q <= 1'b0;
    end

    // Present the request in the selected mode, gated by the enable.
    always_comb begin
        req_o = en_i & (edge_mode_i ? lat_q : pin_i);
    end

    // R3
    pin_latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode_i && pin_i && !pin_prev_q) |=> lat_q);
    // R6
    pin_latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(pin_i && !pin_prev_q)) |=> !lat_q);
endmodule

// File: rtl/cse_wake_src.sv
// Wakeup source: a rising request sets a pending bit that holds power-down
// until acknowledged. Assumes ack_i is a one-cycle pulse from the status register.
module cse_wake_src (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_i,
    input  logic ack_i,
    input  logic en_i,
    output logic req_o,
    output logic hold_o
);
    logic wake_prev_q;
    logic pend_q;

    // Keep last request value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) wake_prev_q <= 1'b0;
        else        wake_prev_q <= wake_i;
    end

    // Pending bit: set on a rising request, cleared only by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                      pend_q <= 1'b0;
        else if (wake_i && !wake_prev_q) pend_q <= 1'b1;
        else if (ack_i)                  pend_q <= 1'b0;
    end

    // Drive the request (enabled) and the hold (unconditional).
    always_comb begin
        req_o  = en_i & pend_q;
        hold_o = pend_q;
    end

    // R7
    wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !ack_i) |=> pend_q);
endmodule

// File: rtl/cse_prio_enc.sv
// Fixed-priority encoder: the lowest set index wins.
// Assumes N <= 2**W. The clock is used only by the checker.
module cse_prio_enc #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    output logic         any_o,
    output logic [W-1:0] code_o,
    output logic [N-1:0] grant_o
);
    // Scan from the top so the lowest active index is applied last.
    always_comb begin
        grant_o = '0;
        code_o  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                grant_o    = '0;
                grant_o[i] = 1'b1;
                code_o     = W'(i);
            end
        end
        any_o = |req_i;
    end

    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o) && (any_o == (grant_o != '0)));
endmodule

// File: rtl/cse_stat_reg.sv
// Status register with flag and code, flag-write decode, wakeup acknowledge
// and read mux. Assumes a single-cycle bus on which reads have no side effect.
module cse_stat_reg #(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 4,
    parameter int STAT_ADDR  = 0,
    parameter int FLAG_BIT   = 10,
    parameter int SHADOW_BIT = 0,
    parameter int CODE_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              route_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              reeval_o,
    output logic              ack_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int CODE_LSB = FLAG_BIT - CODE_W;

    logic              flag_q;
    logic [CODE_W-1:0] code_q;
    logic              sel;

    assign sel = (addr_i == ADDR_W'(STAT_ADDR));

    // Decode the flag write and the wakeup acknowledge it may carry.
    always_comb begin
        reeval_o = sel & we_i & wdata_i[FLAG_BIT];
        ack_o    = reeval_o & flag_q & (&code_q);
    end

    // Field: cleared by a flag write, tracks the encoder while idle, frozen while flagged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            code_q <= '0;
        end else if (reeval_o) begin
            flag_q <= 1'b0;
            code_q <= '0;
        end else if (!flag_q) begin
            flag_q <= any_i;
            code_q <= code_i;
        end
    end

    // Read mux: field and routing copy at the status address, zero elsewhere.
    always_comb begin
        rdata_o = '0;
        if (sel) begin
            rdata_o[FLAG_BIT]                = flag_q;
            rdata_o[CODE_LSB +: CODE_W]      = code_q;
            rdata_o[SHADOW_BIT]              = route_i;
        end
    end

    // R4
    stat_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !reeval_o) |=> (flag_q && $stable(code_q)));
    // R5
    reeval_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reeval_o |=> (!flag_q && code_q == '0));
endmodule

// File: rtl/crit_stat_enc.sv
// Critical interrupt status encoder top: four sources, priority encoding,
// status register and output steering. Assumes all inputs are synchronous to clk.
module crit_stat_enc #(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 4,
    parameter int STAT_ADDR  = 0,
    parameter int FLAG_BIT   = 10,
    parameter int SHADOW_BIT = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pin_irq_i,
    input  logic                     pin_edge_i,
    input  logic                     pin_clr_i,
    input  logic                     tmr_tick_i,
    input  logic                     phi_sum_i,
    input  logic                     wake_req_i,
    input  logic [cse_pkg::N_SRC-1:0] src_en_i,
    input  logic                     route_norm_i,
    input  logic [ADDR_W-1:0]        reg_addr_i,
    input  logic                     reg_we_i,
    input  logic [DATA_W-1:0]        reg_wdata_i,
    output logic [DATA_W-1:0]        reg_rdata_o,
    output logic                     crit_irq_o,
    output logic                     norm_irq_o,
    output logic                     pwr_hold_o
);
    import cse_pkg::*;

    logic [N_SRC-1:0]  req;
    logic [N_SRC-1:0]  grant;
    logic [CODE_W-1:0] enc_code;
    logic              enc_any;
    logic              reeval;
    logic              wake_ack;

    cse_pin_src u_pin (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_irq_i), .edge_mode_i(pin_edge_i),
        .clr_i(reeval | pin_clr_i), .en_i(src_en_i[SRC_PIN]), .req_o(req[SRC_PIN])
    );

    // Level sources pass through, gated by their enables.
    always_comb begin
        req[SRC_TMR] = src_en_i[SRC_TMR] & tmr_tick_i;
        req[SRC_PHI] = src_en_i[SRC_PHI] & phi_sum_i;
    end

    cse_wake_src u_wake (
        .clk(clk), .rst_n(rst_n), .wake_i(wake_req_i), .ack_i(wake_ack),
        .en_i(src_en_i[SRC_WAKE]), .req_o(req[SRC_WAKE]), .hold_o(pwr_hold_o)
    );

    cse_prio_enc #(.N(N_SRC), .W(CODE_W)) u_enc (
        .clk(clk), .rst_n(rst_n), .req_i(req),
        .any_o(enc_any), .code_o(enc_code), .grant_o(grant)
    );

    cse_stat_reg #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR),
        .FLAG_BIT(FLAG_BIT), .SHADOW_BIT(SHADOW_BIT), .CODE_W(CODE_W)
    ) u_stat (
        .clk(clk), .rst_n(rst_n), .any_i(enc_any), .code_i(enc_code),
        .route_i(route_norm_i), .addr_i(reg_addr_i), .we_i(reg_we_i),
        .wdata_i(reg_wdata_i), .reeval_o(reeval), .ack_o(wake_ack),
        .rdata_o(reg_rdata_o)
    );

    // Steer the combined request to exactly one output.
    always_comb begin
        crit_irq_o = enc_any & ~route_norm_i;
        norm_irq_o = enc_any & route_norm_i;
    end

    // R8
    steer_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(crit_irq_o && norm_irq_o) && ((crit_irq_o || norm_irq_o) == (grant != '0)));
endmodule

// File: tb/crit_stat_enc_tb_top.sv
module crit_stat_enc_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin = 0, emode = 0, eclr = 0, tmr = 0, phi = 0, wake = 0, route = 0;
    logic [3:0]  en = 4'hF;
    logic [3:0]  addr = 0;
    logic        we = 0;
    logic [31:0] wdata = 0;
    logic [31:0] rdata;
    logic        crit, norm, hold;

    int total = 0;
    int bad = 0;

    // bench model state
    logic m_prev = 0, m_lat = 0, m_wprev = 0, m_wake = 0, m_flag = 0;
    logic [1:0] m_code = 0;

    always #5 clk = ~clk;

    crit_stat_enc dut_i (
        .clk(clk), .rst_n(rst_n), .pin_irq_i(pin), .pin_edge_i(emode),
        .pin_clr_i(eclr), .tmr_tick_i(tmr), .phi_sum_i(phi), .wake_req_i(wake),
        .src_en_i(en), .route_norm_i(route), .reg_addr_i(addr), .reg_we_i(we),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .crit_irq_o(crit),
        .norm_irq_o(norm), .pwr_hold_o(hold)
    );

    function automatic logic [3:0] act_vec();
        act_vec[0] = en[0] & (emode ? m_lat : pin);
        act_vec[1] = en[1] & tmr;
        act_vec[2] = en[2] & phi;
        act_vec[3] = en[3] & m_wake;
    endfunction

    function automatic logic [1:0] low_code(input logic [3:0] v);
        low_code = 2'd0;
        for (int i = 3; i >= 0; i--) if (v[i]) low_code = 2'(i);
    endfunction

    function automatic logic [31:0] exp_rd();
        exp_rd = 32'h0;
        if (addr == 4'd0) exp_rd = (32'(m_flag) << 10) | (32'(m_code) << 8) | 32'(route);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: check outputs against the model, then advance the model past the edge.
    task automatic step(input string tag);
        logic [3:0] a;
        logic reev, ack, rise;
        @(negedge clk);
        a = act_vec();
        chk({tag, "/R1 rdata"}, rdata, exp_rd());
        chk({tag, "/R8 crit"}, 32'(crit), 32'((|a) & ~route));
        chk({tag, "/R8 norm"}, 32'(norm), 32'((|a) & route));
        chk({tag, "/R7 hold"}, 32'(hold), 32'(m_wake));
        @(posedge clk);
        #1;
        reev = we && addr == 4'd0 && wdata[10];
        ack  = reev && m_flag && m_code == 2'd3;
        rise = emode && pin && !m_prev;
        if (!emode) m_lat = 0; else if (rise) m_lat = 1; else if (reev || eclr) m_lat = 0;
        if (wake && !m_wprev) m_wake = 1; else if (ack) m_wake = 0;
        if (reev) begin m_flag = 0; m_code = 0; end
        else if (!m_flag) begin m_flag = |a; m_code = low_code(a); end
        m_prev = pin;
        m_wprev = wake;
    endtask

    task automatic flag_wr(input string tag, input logic f);
        we = 1; addr = 0; wdata = f ? 32'h400 : 32'hFFFF_FBFF;
        step(tag);
        we = 0; wdata = 0;
    endtask

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset rdata", rdata, 32'h0);
        chk("R7 reset hold", 32'(hold), 32'h0);
        rst_n = 1;

        // R2: several at once, lowest code wins
        tmr = 1; phi = 1; pin = 1;
        repeat (2) step("R2");
        flag_wr("R2", 1); pin = 0;
        repeat (2) step("R2");
        flag_wr("R2", 1); tmr = 0;
        repeat (2) step("R2");
        flag_wr("R2", 1); phi = 0;
        repeat (2) step("R2");

        // R3: level pulse vanishes; edge pulse is kept
        pin = 1; step("R3"); pin = 0; repeat (2) step("R3");
        emode = 1; pin = 1; step("R3"); pin = 0; repeat (3) step("R3");
        // R4: timer appears while pin frozen
        tmr = 1; repeat (2) step("R4");
        // R5: flag bit clear does nothing, set re-evaluates
        flag_wr("R5", 0); step("R5");
        flag_wr("R5", 1); repeat (2) step("R5");
        tmr = 0; flag_wr("R5", 1); repeat (2) step("R5");
        // R6: edge clear pulse, and both clears together
        pin = 1; step("R6"); pin = 0; step("R6");
        eclr = 1; step("R6"); eclr = 0; repeat (2) step("R6");
        pin = 1; step("R6"); pin = 0; step("R6");
        eclr = 1; flag_wr("R6", 1); eclr = 0; repeat (2) step("R6");
        // R7: wakeup held through a wrong-code flag write, released by a proper ack
        emode = 0; wake = 1; step("R7"); wake = 0; pin = 1; repeat (2) step("R7");
        flag_wr("R7", 1); repeat (2) step("R7");
        pin = 0; flag_wr("R7", 1); repeat (2) step("R7");
        flag_wr("R7", 1); repeat (2) step("R7");
        // R9: disabled sources, hold unaffected
        en = 4'h0; wake = 1; tmr = 1; step("R9"); wake = 0; repeat (2) step("R9");
        en = 4'hF; route = 1; repeat (2) step("R9");
        flag_wr("R9", 1); repeat (2) step("R9");
        tmr = 0; flag_wr("R9", 1); repeat (2) step("R9");
        // R10: reads of every address change nothing
        for (int i = 0; i < 4; i++) begin addr = 4'(i); step("R10"); end
        addr = 0;

        // random phase
        for (int c = 0; c < 4000; c++) begin
            pin   = ($urandom % 3) == 0;
            if (($urandom % 40) == 0) emode = ~emode;
            eclr  = ($urandom % 12) == 0;
            tmr   = ($urandom % 5) == 0;
            phi   = ($urandom % 6) == 0;
            wake  = ($urandom % 30) == 0;
            en    = (($urandom % 4) == 0) ? 4'($urandom) : 4'hF;
            route = ($urandom % 4) == 0;
            we    = ($urandom % 5) == 0;
            addr  = (($urandom % 3) == 0) ? 4'($urandom % 4) : 4'd0;
            wdata = $urandom;
            step("R2 rnd");
        end
        we = 0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule